// File: doc/BRIEF.md
# Address-Written DMA Pointer and Control Register File

This block is the register bank of a memory controller in which software updates registers purely through the address of a write. The data bus plays no part. When the zone decoder upstream recognises a write to the DMA/control window, it raises `wr_en` and passes the low address bits. Three of those bits choose a target. Bits 20 down to 6 supply a pointer value, and bits 12 down to 2 supply the control fields.

Six pointers feed the video and sound DMA engines: the display frame start, the video buffer start and end, the cursor start, and the next sound buffer start and end. A seventh select code stores nothing and only emits a one-cycle sound buffer swap strobe. The eighth select code loads a control register. Its decoded fields drive OS mode, the two DMA enables, the refresh mode, the ROM timings and the page size. Each control write also sends a one-cycle "map dirty" strobe to the address translator.

Every output is registered. A write sampled at a rising edge is visible from just after that edge.

Top module: `memc_dma_ctl_regs`

## Requirements
- R1: A synchronous active-low reset overrides any write in the same cycle. Reset clears all six pointers to zero, drops both strobes, and clears OS mode and both DMA enables. It also sets refresh to none (00), both ROM timings to 450 ns (00) and the page size to 4 KB (00).
- R2: A write with select bits wr_addr[19:17] equal to 0, 1, 2, 3, 4 or 5 loads the target pointer. The codes select, in that order, frame start, buffer start, buffer end, cursor start, sound next start and sound next end. The loaded value is (address AND 0x1FFFC0) shifted left by two, so output bits [22:8] equal wr_addr[20:6] and bits [7:0] are zero. The new value appears after the capturing edge.
- R3: No pointer or control field changes in a cycle where wr_en is low, whatever wr_addr holds. A pointer write leaves the other five pointers and the control fields unchanged.
- R4: A write with select code 6 raises snd_swap for exactly the following cycle. It changes no pointer and no control field.
- R5: A write with select code 7 loads os_mode from address bit 12, snd_dma_en from bit 11 and vid_dma_en from bit 10.
- R6: On a control write, address bits [9:8] set refresh_mode. The value 01 gives 01 (during flyback), 11 gives 11 (continuous), and 00 or 10 give 00 (none). refresh_mode never reads 10.
- R7: On a control write, bits [7:6] load rom_hi_time and bits [5:4] load rom_lo_time. Both use the code 00=450 ns, 01=325 ns, 10=200 ns, 11=200 ns with 60 ns nibble mode.
- R8: On a control write, bits [3:2] load page_size with the code 00=4 KB, 01=8 KB, 10=16 KB, 11=32 KB.
- R9: map_dirty is high for the cycle after each control write and low at all other times.
- R10: Writes on consecutive cycles each take effect. Consecutive swap or control writes hold their strobe high for one cycle per write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Zone decoder flags a write to the DMA/control window |
| wr_addr | input | 19 | Write address bits [20:2] |
| vid_frame_ptr | output | 23 | Video frame start pointer |
| vid_buf_start | output | 23 | Video buffer start pointer |
| vid_buf_end | output | 23 | Video buffer end pointer |
| vid_cursor_ptr | output | 23 | Cursor start pointer |
| snd_next_start | output | 23 | Next sound buffer start pointer |
| snd_next_end | output | 23 | Next sound buffer end pointer |
| snd_swap | output | 1 | One-cycle sound buffer swap strobe |
| os_mode | output | 1 | OS mode flag |
| snd_dma_en | output | 1 | Sound DMA enable |
| vid_dma_en | output | 1 | Video DMA enable |
| refresh_mode | output | 2 | DRAM refresh mode (00 none, 01 flyback, 11 continuous) |
| rom_hi_time | output | 2 | High ROM access time code |
| rom_lo_time | output | 2 | Low ROM access time code |
| page_size | output | 2 | Page size code |
| map_dirty | output | 1 | One-cycle strobe to the address translator |

## Verification
The assertions assume that `wr_en` and `wr_addr` are free of X or Z whenever reset is released. They also assume that `wr_en` is already qualified by the zone decoder, so every raised cycle counts as one real write. The bench drives both inputs only at falling edges, holds every sample of `wr_addr` fully defined, and lowers `wr_en` after each burst. This lets both strobes return low and be seen low. Idle cycles keep an address on the bus that would match a control or pointer target, so the ignore rule is exercised under the same conditions the properties rely on.

// File: rtl/memc_dma_pkg.sv
// Shared types and field positions for the address-written DMA/control
// register file. Assumes the control fields sit in write-address bits 12..2.
package memc_dma_pkg;

    typedef enum logic [1:0] {
        REFRESH_NONE    = 2'b00,
        REFRESH_FLYBACK = 2'b01,
        REFRESH_CONT    = 2'b11
    } refresh_e;

    typedef enum logic [1:0] {
        ROM_450NS     = 2'b00,
        ROM_325NS     = 2'b01,
        ROM_200NS     = 2'b10,
        ROM_200NS_NIB = 2'b11
    } rom_time_e;

    typedef enum logic [1:0] {
        PAGE_4K  = 2'b00,
        PAGE_8K  = 2'b01,
        PAGE_16K = 2'b10,
        PAGE_32K = 2'b11
    } page_e;

    typedef struct packed {
        logic      os_mode;
        logic      snd_dma_en;
        logic      vid_dma_en;
        refresh_e  refresh;
        rom_time_e rom_hi;
        rom_time_e rom_lo;
        page_e     page;
    } ctl_t;

    // Address bit positions of the control fields (decoded by neighbours).
    localparam int CTL_MSB      = 12;
    localparam int CTL_LSB      = 2;
    localparam int CTL_OS_BIT   = 12;
    localparam int CTL_SDMA_BIT = 11;
    localparam int CTL_VDMA_BIT = 10;
    localparam int CTL_RF_LSB   = 8;
    localparam int CTL_HI_LSB   = 6;
    localparam int CTL_LO_LSB   = 4;
    localparam int CTL_PG_LSB   = 2;

    // Select codes: 0..NUM_PTR-1 are pointers, then swap, then control.
    localparam int NUM_PTR  = 6;
    localparam int SEL_SWAP = 6;
    localparam int SEL_CTL  = 7;

    localparam ctl_t CTL_RESET = '{
        os_mode:    1'b0,
        snd_dma_en: 1'b0,
        vid_dma_en: 1'b0,
        refresh:    REFRESH_NONE,
        rom_hi:     ROM_450NS,
        rom_lo:     ROM_450NS,
        page:       PAGE_4K
    };

    // Maps the raw two-bit refresh code; the unused code 10 folds to none.
    function automatic refresh_e refresh_from_raw(input logic [1:0] raw);
        case (raw)
            2'b01:   return REFRESH_FLYBACK;
            2'b11:   return REFRESH_CONT;
            default: return REFRESH_NONE;
        endcase
    endfunction

endpackage

// File: rtl/memc_dma_sel_decode.sv
// Turns the select field of a qualified write into one strobe per target.
// Assumes wr_en is already qualified by the zone decoder.
module memc_dma_sel_decode #(
    parameter int SEL_W = 3
) (
    input  logic                    wr_en,
    input  logic [SEL_W-1:0]        sel,
    output logic [(1<<SEL_W)-1:0]   strobe
);

    localparam int NSEL = 1 << SEL_W;

    // One comparator per select code.
    for (genvar g = 0; g < NSEL; g++) begin : g_strobe
        assign strobe[g] = wr_en && (sel == SEL_W'(g));
    end

endmodule

// File: rtl/memc_dma_ptr_bank.sv
// Bank of pointer registers, each loaded from the shared address field when
// its strobe is high. Assumes at most one load strobe per cycle.
module memc_dma_ptr_bank #(
    parameter int NUM    = 6,
    parameter int FIELD_W = 15
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM-1:0]                load,
    input  logic [FIELD_W-1:0]            field,
    output logic [NUM-1:0][FIELD_W-1:0]   ptr_q
);

    for (genvar i = 0; i < NUM; i++) begin : g_ptr
        // Holds pointer i; clears on reset, loads on its own strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)       ptr_q[i] <= '0;
            else if (load[i]) ptr_q[i] <= field;
        end
    end

endmodule

// File: rtl/memc_dma_ctl_field.sv
// Control register: decodes the address-borne control bits into typed
// fields and raises a one-cycle map-dirty strobe on each load.
// Assumes raw carries address bits CTL_MSB..CTL_LSB.
module memc_dma_ctl_field
    import memc_dma_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [CTL_MSB:CTL_LSB]  raw,
    output ctl_t                    ctl_q,
    output logic                    dirty_q
);

    ctl_t ctl_d;

    // Decodes the raw address bits into the next control value.
    always_comb begin
        ctl_d.os_mode    = raw[CTL_OS_BIT];
        ctl_d.snd_dma_en = raw[CTL_SDMA_BIT];
        ctl_d.vid_dma_en = raw[CTL_VDMA_BIT];
        ctl_d.refresh    = refresh_from_raw(raw[CTL_RF_LSB +: 2]);
        ctl_d.rom_hi     = rom_time_e'(raw[CTL_HI_LSB +: 2]);
        ctl_d.rom_lo     = rom_time_e'(raw[CTL_LO_LSB +: 2]);
        ctl_d.page       = page_e'(raw[CTL_PG_LSB +: 2]);
    end

    // Holds the control fields; reset forces the defined defaults.
    always_ff @(posedge clk) begin
        if (!rst_n)    ctl_q <= CTL_RESET;
        else if (load) ctl_q <= ctl_d;
    end

    // Emits the map-dirty strobe for one cycle per control write.
    always_ff @(posedge clk) begin
        if (!rst_n) dirty_q <= 1'b0;
        else        dirty_q <= load;
    end

endmodule

// File: rtl/memc_dma_ctl_regs.sv
// Top of the address-written register file. The value written comes from
// wr_addr; bits [SEL_LSB+:SEL_W] pick the target. Assumes wr_addr spans
// bits ADDR_MSB..ADDR_LSB with ADDR_LSB equal to the lowest control bit.
module memc_dma_ctl_regs
    import memc_dma_pkg::*;
#(
    parameter int ADDR_MSB  = 20,
    parameter int ADDR_LSB  = 2,
    parameter int SEL_LSB   = 17,
    parameter int SEL_W     = 3,
    parameter int FIELD_MSB = 20,
    parameter int FIELD_LSB = 6,
    parameter int PTR_SHIFT = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_MSB:ADDR_LSB]    wr_addr,
    output logic [FIELD_MSB+PTR_SHIFT:0] vid_frame_ptr,
    output logic [FIELD_MSB+PTR_SHIFT:0] vid_buf_start,
    output logic [FIELD_MSB+PTR_SHIFT:0] vid_buf_end,
    output logic [FIELD_MSB+PTR_SHIFT:0] vid_cursor_ptr,
    output logic [FIELD_MSB+PTR_SHIFT:0] snd_next_start,
    output logic [FIELD_MSB+PTR_SHIFT:0] snd_next_end,
    output logic                        snd_swap,
    output logic                        os_mode,
    output logic                        snd_dma_en,
    output logic                        vid_dma_en,
    output logic [1:0]                  refresh_mode,
    output logic [1:0]                  rom_hi_time,
    output logic [1:0]                  rom_lo_time,
    output logic [1:0]                  page_size,
    output logic                        map_dirty
);

    localparam int FIELD_W = FIELD_MSB - FIELD_LSB + 1;
    localparam int LOW_Z   = FIELD_LSB + PTR_SHIFT;
    localparam int NSEL    = 1 << SEL_W;

    logic [NSEL-1:0]                 strobe;
    logic [NUM_PTR-1:0][FIELD_W-1:0] ptr_q;
    ctl_t                            ctl_q;
    logic                            swap_q;
    logic                            dirty_q;

    memc_dma_sel_decode #(
        .SEL_W (SEL_W)
    ) u_decode (
        .wr_en  (wr_en),
        .sel    (wr_addr[SEL_LSB +: SEL_W]),
        .strobe (strobe)
    );

    memc_dma_ptr_bank #(
        .NUM     (NUM_PTR),
        .FIELD_W (FIELD_W)
    ) u_ptrs (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (strobe[NUM_PTR-1:0]),
        .field (wr_addr[FIELD_MSB:FIELD_LSB]),
        .ptr_q (ptr_q)
    );

    memc_dma_ctl_field u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (strobe[SEL_CTL]),
        .raw     (wr_addr[CTL_MSB:CTL_LSB]),
        .ctl_q   (ctl_q),
        .dirty_q (dirty_q)
    );

    // Emits the sound buffer swap strobe for one cycle per swap write.
    always_ff @(posedge clk) begin
        if (!rst_n) swap_q <= 1'b0;
        else        swap_q <= strobe[SEL_SWAP];
    end

    // Pointers leave the bank as stored fields with the zeroed low bits.
    assign vid_frame_ptr  = {ptr_q[0], {LOW_Z{1'b0}}};
    assign vid_buf_start  = {ptr_q[1], {LOW_Z{1'b0}}};
    assign vid_buf_end    = {ptr_q[2], {LOW_Z{1'b0}}};
    assign vid_cursor_ptr = {ptr_q[3], {LOW_Z{1'b0}}};
    assign snd_next_start = {ptr_q[4], {LOW_Z{1'b0}}};
    assign snd_next_end   = {ptr_q[5], {LOW_Z{1'b0}}};

    assign snd_swap     = swap_q;
    assign map_dirty    = dirty_q;
    assign os_mode      = ctl_q.os_mode;
    assign snd_dma_en   = ctl_q.snd_dma_en;
    assign vid_dma_en   = ctl_q.vid_dma_en;
    assign refresh_mode = ctl_q.refresh;
    assign rom_hi_time  = ctl_q.rom_hi;
    assign rom_lo_time  = ctl_q.rom_lo;
    assign page_size    = ctl_q.page;

endmodule

// File: rtl/memc_dma_ctl_regs_chk.sv
// Checker bound to memc_dma_ctl_regs; observes ports only.
// Assumes wr_en and wr_addr are defined whenever reset is released.
module memc_dma_ctl_regs_chk #(
    parameter int ADDR_MSB  = 20,
    parameter int ADDR_LSB  = 2,
    parameter int SEL_LSB   = 17,
    parameter int SEL_W     = 3,
    parameter int FIELD_MSB = 20,
    parameter int FIELD_LSB = 6,
    parameter int PTR_SHIFT = 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         wr_en,
    input logic [ADDR_MSB:ADDR_LSB]     wr_addr,
    input logic [FIELD_MSB+PTR_SHIFT:0] vid_frame_ptr,
    input logic [FIELD_MSB+PTR_SHIFT:0] vid_buf_start,
    input logic [FIELD_MSB+PTR_SHIFT:0] vid_buf_end,
    input logic [FIELD_MSB+PTR_SHIFT:0] vid_cursor_ptr,
    input logic [FIELD_MSB+PTR_SHIFT:0] snd_next_start,
    input logic [FIELD_MSB+PTR_SHIFT:0] snd_next_end,
    input logic                         snd_swap,
    input logic                         os_mode,
    input logic                         snd_dma_en,
    input logic                         vid_dma_en,
    input logic [1:0]                   refresh_mode,
    input logic [1:0]                   rom_hi_time,
    input logic [1:0]                   rom_lo_time,
    input logic [1:0]                   page_size,
    input logic                         map_dirty
);

    localparam int LOW_Z = FIELD_LSB + PTR_SHIFT;

    logic [SEL_W-1:0] sel;
    logic             is_swap;
    logic             is_ctl;
    logic [137:0]     all_ptrs;
    logic [10:0]      all_ctl;

    assign sel      = wr_addr[SEL_LSB +: SEL_W];
    assign is_swap  = wr_en && (sel == SEL_W'(6));
    assign is_ctl   = wr_en && (sel == SEL_W'(7));
    assign all_ptrs = {vid_frame_ptr, vid_buf_start, vid_buf_end,
                       vid_cursor_ptr, snd_next_start, snd_next_end};
    assign all_ctl  = {os_mode, snd_dma_en, vid_dma_en, refresh_mode,
                       rom_hi_time, rom_lo_time, page_size};

    // R2: frame and sound-end pointers take the address field
    p_frame_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_W'(0)) |=>
        vid_frame_ptr == {$past(wr_addr[FIELD_MSB:FIELD_LSB]), {LOW_Z{1'b0}}});

    p_sndend_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_W'(5)) |=>
        snd_next_end == {$past(wr_addr[FIELD_MSB:FIELD_LSB]), {LOW_Z{1'b0}}});

    // R3: idle cycles change nothing
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(all_ptrs) && $stable(all_ctl)));

    // R4: swap write pulses swap and touches no register
    p_swap_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        is_swap |=> (snd_swap && $stable(all_ptrs) && $stable(all_ctl)));

    p_swap_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        snd_swap |-> $past(is_swap));

    // R5: control flags follow address bits 12..10
    p_ctl_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
        is_ctl |=> ({os_mode, snd_dma_en, vid_dma_en} == $past(wr_addr[12:10])));

    // R6: the unused refresh code never appears
    p_refresh_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_mode != 2'b10);

    // R8: page size follows address bits 3..2
    p_page_r8: assert property (@(posedge clk) disable iff (!rst_n)
        is_ctl |=> (page_size == $past(wr_addr[3:2])));

    // R9: map-dirty follows each control write and nothing else
    p_dirty_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        is_ctl |=> map_dirty);

    p_dirty_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        map_dirty |-> $past(is_ctl));

endmodule

bind memc_dma_ctl_regs memc_dma_ctl_regs_chk #(
    .ADDR_MSB  (ADDR_MSB),
    .ADDR_LSB  (ADDR_LSB),
    .SEL_LSB   (SEL_LSB),
    .SEL_W     (SEL_W),
    .FIELD_MSB (FIELD_MSB),
    .FIELD_LSB (FIELD_LSB),
    .PTR_SHIFT (PTR_SHIFT)
) chk_i (.*);

// File: tb/memc_dma_ctl_regs_tb_top.sv
// Scoreboard bench: the driver task applies a write and queues the expected
// port state; the monitor pops and compares once the state is due.
module memc_dma_ctl_regs_tb_top;

    typedef struct packed {
        logic [5:0][22:0] ptr;
        logic             swap;
        logic             os;
        logic             sdma;
        logic             vdma;
        logic [1:0]       rf;
        logic [1:0]       hi;
        logic [1:0]       lo;
        logic [1:0]       pg;
        logic             dirty;
        logic [3:0]       req;
        int               due;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [20:2] wr_addr = '0;
    logic [22:0] vid_frame_ptr, vid_buf_start, vid_buf_end, vid_cursor_ptr;
    logic [22:0] snd_next_start, snd_next_end;
    logic        snd_swap, os_mode, snd_dma_en, vid_dma_en, map_dirty;
    logic [1:0]  refresh_mode, rom_hi_time, rom_lo_time, page_size;

    int   total = 0;
    int   bad = 0;
    int   cyc = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    // Model state built from the requirements.
    logic [5:0][22:0] m_ptr = '0;
    logic       m_os = 0, m_sdma = 0, m_vdma = 0;
    logic [1:0] m_rf = 0, m_hi = 0, m_lo = 0, m_pg = 0;

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    memc_dma_ctl_regs dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .vid_frame_ptr(vid_frame_ptr), .vid_buf_start(vid_buf_start),
        .vid_buf_end(vid_buf_end), .vid_cursor_ptr(vid_cursor_ptr),
        .snd_next_start(snd_next_start), .snd_next_end(snd_next_end),
        .snd_swap(snd_swap), .os_mode(os_mode), .snd_dma_en(snd_dma_en),
        .vid_dma_en(vid_dma_en), .refresh_mode(refresh_mode),
        .rom_hi_time(rom_hi_time), .rom_lo_time(rom_lo_time),
        .page_size(page_size), .map_dirty(map_dirty)
    );

    task automatic chk(input string what, input int req, input logic [22:0] act,
                       input logic [22:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d %s: actual=%h expected=%h (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    // Builds an address with the given select code and payload bits.
    function automatic logic [20:2] mk(input int sel, input logic [18:0] bits);
        logic [20:2] a;
        a = bits;
        a[19:17] = 3'(sel);
        return a;
    endfunction

    // Builds a control-write address from its fields.
    function automatic logic [20:2] mkctl(input logic os, input logic sd, input logic vd,
                                          input logic [1:0] rf, input logic [1:0] hi,
                                          input logic [1:0] lo, input logic [1:0] pg,
                                          input logic [1:0] hi_junk);
        logic [20:2] a;
        a = '0;
        a[20] = hi_junk[1];
        a[16] = hi_junk[0];
        a[19:17] = 3'd7;
        a[12] = os; a[11] = sd; a[10] = vd;
        a[9:8] = rf; a[7:6] = hi; a[5:4] = lo; a[3:2] = pg;
        return a;
    endfunction

    function automatic exp_t snap(input logic sw, input logic dty, input int req);
        exp_t e;
        e.ptr = m_ptr; e.swap = sw; e.os = m_os; e.sdma = m_sdma; e.vdma = m_vdma;
        e.rf = m_rf; e.hi = m_hi; e.lo = m_lo; e.pg = m_pg; e.dirty = dty;
        e.req = 4'(req); e.due = cyc + 1;
        return e;
    endfunction

    // Driver: applies one cycle of input and queues the expected outcome.
    task automatic drive(input logic en, input logic [20:2] a, input int req);
        int sel;
        @(negedge clk);
        wr_en = en;
        wr_addr = a;
        sel = int'(a[19:17]);
        if (en && sel < 6) m_ptr[sel] = {a[20:6], 8'h00};   // R2 formula
        if (en && sel == 7) begin
            m_os = a[12]; m_sdma = a[11]; m_vdma = a[10];
            m_rf = (a[9:8] == 2'b01) ? 2'b01 : (a[9:8] == 2'b11) ? 2'b11 : 2'b00;
            m_hi = a[7:6]; m_lo = a[5:4]; m_pg = a[3:2];
        end
        sb_q.push_back(snap(en && sel == 6, en && sel == 7, req));
    endtask

    // Monitor: compares every queued item once its cycle has come.
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
                exp_t e;
                e = sb_q.pop_front();
                chk("R2/R3 frame ptr",   int'(e.req), vid_frame_ptr,  e.ptr[0]);
                chk("R2/R3 buf start",   int'(e.req), vid_buf_start,  e.ptr[1]);
                chk("R2/R3 buf end",     int'(e.req), vid_buf_end,    e.ptr[2]);
                chk("R2/R3 cursor",      int'(e.req), vid_cursor_ptr, e.ptr[3]);
                chk("R2/R3 snd start",   int'(e.req), snd_next_start, e.ptr[4]);
                chk("R2/R3 snd end",     int'(e.req), snd_next_end,   e.ptr[5]);
                chk("R4 swap strobe",    int'(e.req), 23'(snd_swap),  23'(e.swap));
                chk("R5 flags",          int'(e.req), 23'({os_mode, snd_dma_en, vid_dma_en}),
                    23'({e.os, e.sdma, e.vdma}));
                chk("R6 refresh",        int'(e.req), 23'(refresh_mode), 23'(e.rf));
                chk("R7 rom hi",         int'(e.req), 23'(rom_hi_time),  23'(e.hi));
                chk("R7 rom lo",         int'(e.req), 23'(rom_lo_time),  23'(e.lo));
                chk("R8 page size",      int'(e.req), 23'(page_size),    23'(e.pg));
                chk("R9 map dirty",      int'(e.req), 23'(map_dirty),    23'(e.dirty));
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #2_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] lcg;
        // R1: reset wins over a control write presented during reset
        repeat (2) @(negedge clk);
        wr_en = 1'b1;
        wr_addr = mkctl(1, 1, 1, 2'b11, 2'b11, 2'b11, 2'b11, 2'b11);
        sb_q.push_back(snap(1'b0, 1'b0, 1));
        @(negedge clk);
        rst_n = 1'b1;
        wr_en = 1'b0;
        drive(0, mkctl(1, 1, 1, 2'b01, 2'b01, 2'b01, 2'b01, 2'b00), 1);

        // R2: each pointer code, distinct payloads including all ones
        drive(1, mk(0, 19'h7FFFF), 2);
        drive(1, mk(1, 19'h0AA55), 2);
        drive(1, mk(2, 19'h5A5A5), 2);
        drive(1, mk(3, 19'h00010), 2);
        drive(1, mk(4, 19'h7FFF0), 2);
        drive(1, mk(5, 19'h41234), 2);
        drive(1, mk(0, 19'h00000), 2);
        // R3: idle cycles with pointer and control addresses present
        drive(0, mk(2, 19'h12345), 3);
        drive(0, mkctl(1, 1, 0, 2'b11, 2'b10, 2'b01, 2'b11, 2'b01), 3);

        // R4: swap pulse, then drop; R10: back-to-back swaps
        drive(1, mk(6, 19'h7FFFF), 4);
        drive(0, mk(6, 19'h7FFFF), 4);
        drive(1, mk(6, 19'h01234), 10);
        drive(1, mk(6, 19'h04321), 10);
        drive(0, mk(0, 19'h0), 4);

        // R5..R9: control writes across refresh, ROM and page codes
        drive(1, mkctl(1, 0, 0, 2'b01, 2'b00, 2'b01, 2'b00, 2'b10), 5);
        drive(0, mk(0, 19'h0), 9);
        drive(1, mkctl(0, 1, 0, 2'b10, 2'b01, 2'b10, 2'b01, 2'b01), 6);
        drive(0, mk(7, 19'h0), 9);
        drive(1, mkctl(0, 0, 1, 2'b11, 2'b10, 2'b11, 2'b10, 2'b00), 7);
        drive(0, mk(7, 19'h0), 9);
        drive(1, mkctl(1, 1, 1, 2'b00, 2'b11, 2'b00, 2'b11, 2'b11), 8);
        drive(0, mk(7, 19'h0), 9);
        // R10: consecutive control writes, then pointer right after
        drive(1, mkctl(0, 1, 1, 2'b01, 2'b00, 2'b11, 2'b01, 2'b10), 10);
        drive(1, mkctl(1, 0, 1, 2'b11, 2'b01, 2'b00, 2'b10, 2'b01), 10);
        drive(1, mk(3, 19'h3C3C3), 10);
        drive(1, mk(4, 19'h1111F), 10);
        drive(0, mk(5, 19'h7FFFF), 3);

        // Mixed stream over all codes with pseudo-random payloads
        lcg = 32'h1357_9BDF;
        for (int i = 0; i < 60; i++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            drive(lcg[31] | lcg[30], lcg[28:10], 2);
        end
        drive(0, mk(7, 19'h0), 9);
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule